// File: doc/BRIEF.md
# Clock Monitor Reset Controller

This block watches a system clock against an independent, slower reference clock. When the system clock stops, or runs so slowly that it shows no edge for more than a set number of reference ticks, the block raises a clock-failure reset request. The request is a pulse of fixed length, timed by the reference clock. A two-bit control register holds the detector's enables. One is a software enable bit that can be written freely. The other is a lock bit that can only be set: it forces the monitor on, ignores writes of zero, and clears only on reset.

The same register carries a two-bit rate field for the watchdog's input stage. The system clock first passes through a fixed power-of-two prescaler of 2^PRE_W. The rate field then divides it further by 1, 4, 16 or 64, and the result is a one-cycle watchdog tick. The register port and the prescaler run on the system clock. The detector runs on the reference clock, so it keeps working after the system clock has died. The system clock reaches the detector as a toggle signal through a two-flop synchronizer.

Top module: `clkmon_rst_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `clk_fail_rst` is low.
- R2: Bit 0 of the register is the software enable. A write stores `reg_wdata[0]` there at any time, and the new value reads back from the next cycle.
- R3: Bit 1 is the lock bit. Writing 1 to it sets it. Writing 0 to it leaves it unchanged. Only reset clears it. While it is set, the monitor is enabled even when bit 0 is 0.
- R4: When both bit 0 and bit 1 are 0, the monitor is disabled. A stopped system clock then never raises `clk_fail_rst`, and the timeout and pulse counters are held at zero.
- R5: When the monitor is enabled and the system clock stops, `clk_fail_rst` rises within THRESH+7 reference cycles. It rises only after more than THRESH reference cycles have passed without a detected system-clock edge.
- R6: Each request is high for exactly PULSE_LEN reference cycles.
- R7: No request is raised while the system clock keeps running faster than the reference clock.
- R8: Bits 3:2 form the rate field, writable and readable at any time. `wdog_tick` is high for one system cycle, every 2^PRE_W × 4^rate system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Monitored system clock; clocks the register port and the prescaler |
| ref_clk | input | 1 | Independent reference clock for the detector |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: [0] enable, [1] lock, [3:2] rate |
| reg_rdata | output | 4 | Current register contents, same layout as the write data |
| clk_fail_rst | output | 1 | Clock-failure reset request pulse (reference domain) |
| wdog_tick | output | 1 | Prescaled watchdog tick (system domain) |

## Verification
The bench builds the block with THRESH=8, PULSE_LEN=4 and PRE_W=3. The system clock period is 10 and the reference period is 34, and the system clock can be gated off at will. With these values a dead clock is caught within about a dozen reference cycles, and the pulse width can be counted exactly. All four watchdog rates, with periods of 8, 32, 128 and 512 cycles, each fit in a few hundred cycles. The running-clock case checks that the sampling pattern between the two clocks never leaves THRESH edgeless reference cycles.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned RATE_W = 2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              lock;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/clkmon_sync.sv
// Multi-flop synchronizer; with d tied high it also serves as reset release.
module clkmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
  import clkmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [RATE_W-1:0] rate,
  output logic              eff_en
);
  ctrl_t ctrl_q, ctrl_d;
  logic  eff_q, eff_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.en   = wdata[0];
      ctrl_d.lock = ctrl_q.lock | wdata[1];
      ctrl_d.rate = wdata[REG_W-1:2];
    end
    eff_d = ctrl_d.en | ctrl_d.lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      eff_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      eff_q  <= eff_d;
    end
  end

  assign rdata  = ctrl_q;
  assign rate   = ctrl_q.rate;
  assign eff_en = eff_q;
endmodule

// File: rtl/clkmon_detect.sv
// Reference-domain detector: counts reference ticks since the last seen
// monitored-clock toggle and fires a fixed-length pulse on timeout.
module clkmon_detect #(
  parameter int unsigned THRESH    = 32,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tgl_async,
  input  logic en_async,
  output logic en_sync,
  output logic fail
);
  localparam int unsigned CNT_W = $clog2(THRESH + 1);
  localparam int unsigned PL_W  = $clog2(PULSE_LEN + 1);

  logic             tgl_s, tgl_prev_q, edge_seen;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PL_W-1:0]  pl_q, pl_d;

  clkmon_sync #(.STAGES(2)) u_tgl_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(tgl_async), .q(tgl_s)
  );
  clkmon_sync #(.STAGES(2)) u_en_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(en_async), .q(en_sync)
  );

  assign edge_seen = tgl_s ^ tgl_prev_q;

  always_comb begin
    cnt_d = cnt_q;
    pl_d  = pl_q;
    if (!en_sync) begin
      cnt_d = '0;
      pl_d  = '0;
    end else if (pl_q != '0) begin
      pl_d  = pl_q - PL_W'(1);
      cnt_d = '0;
    end else if (edge_seen) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(THRESH)) begin
      cnt_d = '0;
      pl_d  = PL_W'(PULSE_LEN);
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev_q <= 1'b0;
      cnt_q      <= '0;
      pl_q       <= '0;
    end else begin
      tgl_prev_q <= tgl_s;
      cnt_q      <= cnt_d;
      pl_q       <= pl_d;
    end
  end

  assign fail = (pl_q != '0);
endmodule

// File: rtl/clkmon_prescale.sv
// Fixed 2^PRE_W prescaler followed by a 4^rate selectable divider.
module clkmon_prescale #(
  parameter int unsigned PRE_W  = 15,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned STEP  = 2;
  localparam int unsigned NRATE = 1 << RATE_W;
  localparam int unsigned CW    = PRE_W + STEP * (NRATE - 1);

  logic [CW-1:0] cnt_q, cnt_d, mask;
  logic [CW-1:0] mask_tab [NRATE];
  logic          tick_q, tick_d;

  for (genvar g = 0; g < NRATE; g++) begin : g_mask
    assign mask_tab[g] = CW'((64'd1 << (PRE_W + STEP * g)) - 64'd1);
  end

  always_comb begin
    mask   = mask_tab[rate];
    cnt_d  = cnt_q + CW'(1);
    tick_d = ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/clkmon_rst_ctrl.sv
module clkmon_rst_ctrl
  import clkmon_pkg::*;
#(
  parameter int unsigned THRESH    = 32,
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned PRE_W     = 15
) (
  input  logic             sys_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_fail_rst,
  output logic             wdog_tick
);
  logic              sys_rst_n, ref_rst_n;
  logic              tgl_q, tgl_d;
  logic              eff_en, en_ref;
  logic [RATE_W-1:0] rate;

  clkmon_sync #(.STAGES(2)) u_sys_rst (
    .clk(sys_clk), .rst_n(rst_n), .d(1'b1), .q(sys_rst_n)
  );
  clkmon_sync #(.STAGES(2)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );

  // Activity marker: flips on every system clock edge.
  always_comb tgl_d = ~tgl_q;
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  clkmon_regs u_regs (
    .clk(sys_clk), .rst_n(sys_rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rate(rate), .eff_en(eff_en)
  );

  clkmon_detect #(.THRESH(THRESH), .PULSE_LEN(PULSE_LEN)) u_detect (
    .ref_clk(ref_clk), .rst_n(ref_rst_n), .tgl_async(tgl_q),
    .en_async(eff_en), .en_sync(en_ref), .fail(clk_fail_rst)
  );

  clkmon_prescale #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_pre (
    .clk(sys_clk), .rst_n(sys_rst_n), .rate(rate), .tick(wdog_tick)
  );
endmodule

// File: rtl/clkmon_rst_ctrl_chk.sv
module clkmon_rst_ctrl_chk (
  input logic       sys_clk,
  input logic       ref_clk,
  input logic       sys_rst_n,
  input logic       ref_rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_wdata,
  input logic [3:0] reg_rdata,
  input logic       en_ref,
  input logic       clk_fail_rst,
  input logic       wdog_tick
);
  // R2
  en_write_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    reg_wr |=> reg_rdata[0] == $past(reg_wdata[0]));

  // R3
  lock_set_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (reg_wr && reg_wdata[1]) |=> reg_rdata[1]);

  // R3
  lock_sticky_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    reg_rdata[1] |=> reg_rdata[1]);

  // R4
  disabled_quiet_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !en_ref |=> !clk_fail_rst);

  // R8
  rate_write_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    reg_wr |=> reg_rdata[3:2] == $past(reg_wdata[3:2]));

  // R8
  tick_single_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wdog_tick |=> !wdog_tick);
endmodule

bind clkmon_rst_ctrl clkmon_rst_ctrl_chk u_chk (
  .sys_clk(sys_clk), .ref_clk(ref_clk), .sys_rst_n(sys_rst_n),
  .ref_rst_n(ref_rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .en_ref(en_ref), .clk_fail_rst(clk_fail_rst),
  .wdog_tick(wdog_tick)
);

// File: tb/tb_clkmon_rst_ctrl.sv
module tb_clkmon_rst_ctrl;
  localparam int SYS_PERIOD = 10;
  localparam int REF_PERIOD = 34;
  localparam int THRESH     = 8;
  localparam int PULSE_LEN  = 4;
  localparam int PRE_W      = 3;
  localparam int NVEC       = 7;

  // {wdata, expected rdata}: bit0 enable, bit1 lock, bits3:2 rate
  localparam logic [7:0] VEC [NVEC] = '{
    8'h11, 8'h00, 8'hDD, 8'h66, 8'h02, 8'h13, 8'hCE
  };

  logic       sys_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       sys_run = 1'b1;
  logic       rst_n   = 1'b0;
  logic       reg_wr  = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       clk_fail_rst, wdog_tick;

  int n_chk = 0;
  int n_bad = 0;

  initial forever begin
    #(SYS_PERIOD / 2);
    if (sys_run) sys_clk = ~sys_clk;
  end
  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

  clkmon_rst_ctrl #(.THRESH(THRESH), .PULSE_LEN(PULSE_LEN), .PRE_W(PRE_W)) dut (
    .sys_clk(sys_clk), .ref_clk(ref_clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_fail_rst(clk_fail_rst), .wdog_tick(wdog_tick)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge sys_clk);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge sys_clk);
    reg_wr    = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_wait(3);
    rst_n = 1'b1;
    ref_wait(4);
  endtask

  // Gate the system clock off, report when the request rose and its width.
  task automatic stop_probe(output int rise_at, output int width);
    rise_at = -1;
    width   = 0;
    sys_run = 1'b0;
    for (int i = 0; i < THRESH + 12; i++) begin
      @(negedge ref_clk);
      if (clk_fail_rst) begin
        rise_at = i;
        break;
      end
    end
    if (rise_at >= 0) begin
      width = 1;
      while (width < 100) begin
        @(negedge ref_clk);
        if (!clk_fail_rst) break;
        width++;
      end
    end
    sys_run = 1'b1;
    ref_wait(6);
  endtask

  task automatic tick_interval(output int len);
    int guard = 0;
    len = 0;
    do begin
      @(negedge sys_clk);
      guard++;
    end while (!wdog_tick && guard < 5000);
    do begin
      @(negedge sys_clk);
      len++;
    end while (!wdog_tick && len < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rise, wid, highs, len;
    do_reset();

    // R1: reset state
    check("R1 rdata after reset", int'(reg_rdata), 0);
    check("R1 request after reset", int'(clk_fail_rst), 0);

    // R4: monitor off after reset, dead clock ignored
    stop_probe(rise, wid);
    check("R4 no request when disabled", rise, -1);

    // R7: enabled, running clock, no false alarm
    wr(4'h1);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge ref_clk);
      if (clk_fail_rst) highs++;
    end
    check("R7 no request with running clock", highs, 0);

    // R5 / R6: enabled, clock stops
    stop_probe(rise, wid);
    check("R5 request rises in time", int'(rise >= 0 && rise <= THRESH + 7), 1);
    check("R6 pulse width", wid, PULSE_LEN);

    // R4: disable again, dead clock ignored
    wr(4'h0);
    ref_wait(5);
    stop_probe(rise, wid);
    check("R4 no request after disable", rise, -1);

    // Register vectors (R2 enable, R3 lock, R8 rate field)
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][7:4]);
      check((i < 3) ? "R2 register vector" : "R3 register vector",
            int'(reg_rdata), int'(VEC[i][3:0]));
    end

    // R3: lock alone keeps the monitor on
    ref_wait(5);
    stop_probe(rise, wid);
    check("R3 lock forces request", int'(rise >= 0 && rise <= THRESH + 7), 1);
    check("R6 pulse width under lock", wid, PULSE_LEN);

    // R3 / R1: only reset clears the lock
    do_reset();
    check("R3 reset clears lock", int'(reg_rdata), 0);

    // R8: each rate gives 2^PRE_W * 4^rate cycles between ticks
    for (int r = 0; r < 4; r++) begin
      wr(4'(r << 2));
      tick_interval(len);
      check($sformatf("R8 tick period rate %0d", r), len, (1 << PRE_W) << (2 * r));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule